// File: doc/BRIEF.md
# Option Byte Reset Loader

After every reset release, this block fetches eight stored option-byte pairs from a non-volatile array through a simple synchronous read port. Each pair holds a value byte and a check byte that must be the bitwise inverse of the value. The block validates each pair and writes the result into a bank of shadow registers. The first four pairs drive a 32-bit status word and the last four drive a 32-bit write-protect word.

A pair that fails its check is replaced with 0xFF and sets a sticky error flag. A fully erased pair, with both bytes 0xFF, also loads 0xFF but is not counted as an error. Until the whole walk is complete, every shadow output shows the safe all-ones value and the error output stays low. A done flag then rises and the loaded values become visible. They hold until the next reset.

Top module: `optb_loader`

## Requirements
- R1: After reset release the block asserts `rd_en_o` for exactly 8 consecutive cycles, starting in the first cycle. `rd_addr_o` runs 0,1,...,7 in ascending order, one address per cycle. After that no read is issued until the next reset.
- R2: The storage answers one cycle after a read. `rd_data_i[7:0]` is the value byte of the pair addressed in the previous cycle, and `rd_data_i[15:8]` is its check byte.
- R3: When the check byte equals the bitwise inverse of the value byte, the value byte is loaded unchanged. This includes value 0x00 with check byte 0xFF.
- R4: When the check byte is not the inverse of the value byte, and the pair is not fully erased, 0xFF is loaded for that pair and the error flag is set.
- R5: A pair whose two bytes are both 0xFF loads 0xFF and does not set the error flag.
- R6: `err_o` is the OR of the failure results of all 8 pairs. It stays set until the next reset, and a new reset clears it.
- R7: `done_o` rises 9 clock cycles after the first rising edge that follows reset release, counting that edge as cycle 1. It then stays high until reset.
- R8: While `done_o` is low, `stat_o` and `wp_o` are all ones and `err_o` is low.
- R9: Pair n (n = 0..3) appears on `stat_o[8n+7:8n]`. Pair 4+m (m = 0..3) appears on `wp_o[8m+7:8m]`, so pair 4 is the least significant byte.
- R10: Each reset triggers a full reload. Results reflect the storage contents at that reset, and results from the earlier load are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rd_en_o | output | 1 | Storage read strobe |
| rd_addr_o | output | 3 | Pair index being read |
| rd_data_i | input | 16 | Pair word: value [7:0], check byte [15:8], one cycle after the read |
| stat_o | output | 32 | Shadow status word, pairs 0..3 |
| wp_o | output | 32 | Shadow write-protect word, pairs 4..7, LSB first |
| err_o | output | 1 | Sticky pair-check failure flag |
| done_o | output | 1 | Load complete |

## Verification
The assertions assume the storage behaves as a one-cycle synchronous memory: read data belongs to the address strobed on the previous edge. They also assume reset is held long enough for the loader to restart from address zero. The bench models the storage as exactly that kind of registered array. It changes the array contents only while reset is asserted, so no pair changes while it is being fetched. Each scenario applies a fresh reset, which keeps every walk a full, uninterrupted pass over all eight pairs.

// File: rtl/optb_pkg.sv
package optb_pkg;
  localparam int unsigned OPTB_PAIRS      = 8;
  localparam int unsigned OPTB_BYTE_W     = 8;
  localparam int unsigned OPTB_STAT_PAIRS = 4;
endpackage

// File: rtl/optb_seq.sv
module optb_seq #(
  parameter int unsigned NUM_PAIRS = 8,
  localparam int unsigned AW       = $clog2(NUM_PAIRS),
  localparam int unsigned CNT_W    = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic          rd_en_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          vld_o,
  output logic [AW-1:0] vidx_o,
  output logic          last_o
);
  logic [CNT_W-1:0] issue_q;
  logic             vld_q;
  logic [AW-1:0]    vidx_q;

  assign rd_en_o   = issue_q < CNT_W'(NUM_PAIRS);
  assign rd_addr_o = issue_q[AW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      issue_q <= '0;
      vld_q   <= 1'b0;
      vidx_q  <= '0;
    end else begin
      if (rd_en_o) issue_q <= issue_q + 1'b1;
      vld_q  <= rd_en_o;
      vidx_q <= rd_addr_o;
    end
  end

  assign vld_o  = vld_q;
  assign vidx_o = vidx_q;
  assign last_o = vld_q && (vidx_q == AW'(NUM_PAIRS - 1));

  // R1: consecutive ascending reads
  a_r1_addr_ascend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_o && rd_addr_o != AW'(NUM_PAIRS - 1)) |=>
      (rd_en_o && rd_addr_o == $past(rd_addr_o) + 1'b1));

  // R1: the last read ends the burst
  a_r1_burst_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_o && rd_addr_o == AW'(NUM_PAIRS - 1)) |=> !rd_en_o);
endmodule

// File: rtl/optb_check.sv
module optb_check #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic [BYTE_W-1:0] val_raw_i,
  input  logic [BYTE_W-1:0] chk_raw_i,
  output logic [BYTE_W-1:0] val_o,
  output logic              bad_o
);
  logic match, erased;

  assign match  = (chk_raw_i == ~val_raw_i);
  assign erased = (val_raw_i == '1) && (chk_raw_i == '1);
  assign val_o  = match ? val_raw_i : '1;
  assign bad_o  = !match && !erased;
endmodule

// File: rtl/optb_shadow.sv
module optb_shadow #(
  parameter int unsigned NUM_PAIRS = 8,
  parameter int unsigned BYTE_W    = 8,
  localparam int unsigned AW       = $clog2(NUM_PAIRS),
  localparam int unsigned BANK_W   = NUM_PAIRS * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic [AW-1:0]     vidx_i,
  input  logic              last_i,
  input  logic [BYTE_W-1:0] val_i,
  input  logic              bad_i,
  output logic [BANK_W-1:0] bank_o,
  output logic              err_o,
  output logic              done_o
);
  logic [BANK_W-1:0] bank_q;
  logic              err_q, done_q;

  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) bank_q[g*BYTE_W +: BYTE_W] <= '1;
      else if (vld_i && vidx_i == AW'(g)) bank_q[g*BYTE_W +: BYTE_W] <= val_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (vld_i && bad_i) err_q <= 1'b1;
      if (last_i) done_q <= 1'b1;
    end
  end

  // hold safe values until the walk completes
  assign bank_o = done_q ? bank_q : '1;
  assign err_o  = done_q & err_q;
  assign done_o = done_q;

  // R6: error never clears without reset
  a_r6_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);

  // R4: error rises only after a checked pair
  a_r4_err_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_q) |-> $past(vld_i));
endmodule

// File: rtl/optb_loader.sv
module optb_loader
  import optb_pkg::*;
#(
  parameter int unsigned NUM_PAIRS  = OPTB_PAIRS,
  parameter int unsigned BYTE_W     = OPTB_BYTE_W,
  parameter int unsigned STAT_PAIRS = OPTB_STAT_PAIRS,
  localparam int unsigned AW        = $clog2(NUM_PAIRS),
  localparam int unsigned STAT_W    = STAT_PAIRS * BYTE_W,
  localparam int unsigned WP_W      = (NUM_PAIRS - STAT_PAIRS) * BYTE_W,
  localparam int unsigned BANK_W    = NUM_PAIRS * BYTE_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  output logic                rd_en_o,
  output logic [AW-1:0]       rd_addr_o,
  input  logic [2*BYTE_W-1:0] rd_data_i,
  output logic [STAT_W-1:0]   stat_o,
  output logic [WP_W-1:0]     wp_o,
  output logic                err_o,
  output logic                done_o
);
  logic              vld, last, bad;
  logic [AW-1:0]     vidx;
  logic [BYTE_W-1:0] val;
  logic [BANK_W-1:0] bank;

  optb_seq #(.NUM_PAIRS(NUM_PAIRS)) u_seq (
    .clk_i, .rst_ni,
    .rd_en_o, .rd_addr_o,
    .vld_o(vld), .vidx_o(vidx), .last_o(last)
  );

  optb_check #(.BYTE_W(BYTE_W)) u_check (
    .val_raw_i(rd_data_i[BYTE_W-1:0]),
    .chk_raw_i(rd_data_i[2*BYTE_W-1:BYTE_W]),
    .val_o(val), .bad_o(bad)
  );

  optb_shadow #(.NUM_PAIRS(NUM_PAIRS), .BYTE_W(BYTE_W)) u_shadow (
    .clk_i, .rst_ni,
    .vld_i(vld), .vidx_i(vidx), .last_i(last),
    .val_i(val), .bad_i(bad),
    .bank_o(bank), .err_o, .done_o
  );

  assign stat_o = bank[STAT_W-1:0];
  assign wp_o   = bank[BANK_W-1:STAT_W];

  // R7: done is sticky
  a_r7_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);

  // R1: no reads once loaded
  a_r1_quiet_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !rd_en_o);
endmodule

// File: tb/optb_loader_test.sv
module optb_loader_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rd_en;
  logic [2:0]  rd_addr;
  logic [15:0] rd_data = '0;
  logic [31:0] stat, wp;
  logic        err, done;

  int checks = 0, failures = 0;
  logic [15:0] mem [8];

  typedef struct { logic [31:0] stat; logic [31:0] wp; logic err; } exp_t;
  exp_t exp_q[$];

  always #10 clk = ~clk;

  optb_loader uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .rd_en_o(rd_en), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .stat_o(stat), .wp_o(wp), .err_o(err), .done_o(done)
  );

  // R2: one-cycle registered storage
  always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

  int cyc, rd_cnt;
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin cyc <= 0; rd_cnt <= 0; end
    else begin cyc <= cyc + 1; if (rd_en) rd_cnt <= rd_cnt + 1; end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // monitor
  logic prev_done = 1'b0;
  always @(negedge clk) begin
    if (rst_ni) begin
      if (rd_en) chk(rd_addr == 3'(cyc) && cyc < 8, "R1 addr", 64'(rd_addr), 64'(cyc));
      if (!done) begin
        chk(stat == '1 && wp == '1 && !err, "R8 safe", {stat, wp}, '1);
        chk(cyc < 9, "R7 early", 64'(cyc), 64'd9);
      end
      if (done && !prev_done) begin
        exp_t e;
        if (exp_q.size() == 0) chk(1'b0, "R10 no item", 64'd0, 64'd1);
        else begin
          e = exp_q.pop_front();
          chk(stat == e.stat, "R3/R9 stat", 64'(stat), 64'(e.stat));
          chk(wp == e.wp, "R3/R9 wp", 64'(wp), 64'(e.wp));
          chk(err == e.err, "R4/R5/R6 err", 64'(err), 64'(e.err));
          chk(cyc == 9, "R7 timing", 64'(cyc), 64'd9);
          chk(rd_cnt == 8, "R1 read count", 64'(rd_cnt), 64'd8);
        end
      end
      prev_done <= done;
    end else prev_done <= 1'b0;
  end

  task automatic run_case(input logic [15:0] img [8]);
    exp_t e;
    e.err = 1'b0;
    for (int n = 0; n < 8; n++) begin
      logic [7:0] lo, hi, v;
      lo = img[n][7:0]; hi = img[n][15:8];
      if (hi == ~lo) v = lo;
      else begin v = 8'hFF; if (!(lo == 8'hFF && hi == 8'hFF)) e.err = 1'b1; end
      if (n < 4) e.stat[n*8 +: 8] = v; else e.wp[(n-4)*8 +: 8] = v;
    end
    @(negedge clk); rst_ni = 1'b0;
    for (int n = 0; n < 8; n++) mem[n] = img[n];
    exp_q.push_back(e);
    repeat (2) @(negedge clk);
    #5 rst_ni = 1'b1;
    repeat (15) @(negedge clk);
    chk(done === 1'b1, "R7 done held", 64'(done), 64'd1);
    chk(rd_cnt == 8, "R1 no extra reads", 64'(rd_cnt), 64'd8);
    chk(err == e.err, "R6 err held", 64'(err), 64'(e.err));
  endtask

  initial begin
    logic [15:0] img [8];
    for (int n = 0; n < 8; n++) mem[n] = '0;
    repeat (2) @(negedge clk);
    // valid distinct values (R3, R9)
    for (int n = 0; n < 8; n++) begin
      logic [7:0] v; v = 8'(8'h11 * (n + 1));
      img[n] = {~v, v};
    end
    run_case(img);
    // all erased (R5)
    for (int n = 0; n < 8; n++) img[n] = 16'hFFFF;
    run_case(img);
    // one corrupted write-protect byte (R4)
    for (int n = 0; n < 8; n++) img[n] = {~8'(n + 8'h40), 8'(n + 8'h40)};
    img[5] = 16'h1234;
    run_case(img);
    // mixed: erased, zero value, corrupt last (R3, R4, R5)
    for (int n = 0; n < 8; n++) img[n] = {~8'(8'hA0 + n), 8'(8'hA0 + n)};
    img[0] = 16'hFFFF; img[1] = 16'hFF00; img[7] = 16'h00A5;
    run_case(img);
    // only low byte erased (R4)
    for (int n = 0; n < 8; n++) img[n] = 16'hFF00;
    img[3] = 16'h00FF;
    img[6] = 16'h7FFF;
    run_case(img);
    // clean reload clears previous error (R10)
    for (int n = 0; n < 8; n++) img[n] = {~8'(8'h5A ^ n), 8'(8'h5A ^ n)};
    run_case(img);
    chk(exp_q.size() == 0, "R10 all consumed", 64'(exp_q.size()), 64'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule